// File: doc/BRIEF.md
# Dual-Edge Input Capture Unit

This block timestamps transitions of external input pins. Each channel owns a free-running counter that advances on a shared clock-enable tick, so a prescaler elsewhere sets the time base. When a channel is enabled, every rising transition of its pin copies the counter into that channel's rise register, and every falling transition copies it into the fall register. A pulse width or a period then follows from the difference of two stored values.

Each stored value comes with a loaded flag and an interrupt status bit. Software clears both by writing ones. The interrupt output is the OR of all status bits whose enable bit is set. A per-channel polarity bit inverts the pin ahead of edge detection. With inversion on, a rising pin is filed as a falling edge, and the other way round. The pin passes through a two-flop synchroniser before edge detection, so it may be fully asynchronous to the clock.

Top module: `cap_unit`

## Requirements
- R1: After reset, every counter, capture register, loaded flag, status bit and the interrupt output read zero.
- R2: While a channel's enable bit (bit c of `cap_en`) is low, its counter reads zero. While the bit is high, the counter advances by one on each clock edge at which `tick` is high and holds otherwise.
- R3: The counter is 16 bits wide and wraps from 65535 to 0.
- R4: A rising transition of the pin first sampled at clock edge K is stored in the rise register. The stored value is the counter value held just after edge K+1, and it is visible after edge K+2. The same capture sets loaded bit 2c and status bit 2c.
- R5: A falling transition is stored in the fall register with the same timing. It sets loaded bit 2c+1 and status bit 2c+1, and it leaves the rise register unchanged.
- R6: Writing 1 to a bit of `ld_clr` clears that loaded flag. A new edge overwrites its capture register even while the flag is still set. When a capture and a clear hit the same edge, the flag ends up set.
- R7: Status bits are set by a capture whatever `irq_en` holds. Writing 1 to a bit of `stat_clr` clears that status bit. A capture at the same edge as a clear leaves the bit set.
- R8: `irq` is high exactly when some bit is set in both `irq_stat` and `irq_en`.
- R9: With bit c of `inv_pin` high, a rising pin transition is captured as a falling edge and a falling one as a rising edge.
- R10: A disabled channel ignores pin transitions. Its capture registers, loaded flags and status bits keep their values.
- R11: Channels are independent. Activity on one channel changes no output field of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | NCH | Capture enable, bit c for channel c |
| cap_pin | input | NCH | Asynchronous input pins |
| inv_pin | input | NCH | Input inversion, bit c for channel c |
| tick | input | 1 | Counter clock enable |
| irq_en | input | 2*NCH | Interrupt enables, bit 2c rise, bit 2c+1 fall |
| stat_clr | input | 2*NCH | Write-one-to-clear strobes for the status bits |
| ld_clr | input | 2*NCH | Write-one-to-clear strobes for the loaded flags |
| cap_cnt | output | NCH*16 | Counter values, channel c at bits 16c+15..16c |
| rise_cap | output | NCH*16 | Rise capture registers, same packing |
| fall_cap | output | NCH*16 | Fall capture registers, same packing |
| loaded | output | 2*NCH | Loaded flags, bit 2c rise, bit 2c+1 fall |
| irq_stat | output | 2*NCH | Interrupt status, bit 2c rise, bit 2c+1 fall |
| irq | output | 1 | Interrupt request |

## Verification
A pin change first sampled at edge K is due in the capture register, loaded flag and status bit after edge K+2. The stored value equals the number of ticked edges from the enabling edge E through edge K+1, which is K-E+2 when `tick` stays high. Counter changes and clear strobes take effect one edge after they are sampled, and `irq` follows `irq_en` within the same cycle. The bench keeps its own edge count, drives inputs on falling clock edges, records K and E as it drives them, and samples each result on the falling edge that follows the edge at which it is due.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef logic [1:0] pair_t;  // bit 0 rise, bit 1 fall

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_t;

  // Edge classification of the polarity-adjusted level against its last value.
  function automatic edge_t classify(input logic now_lvl, input logic last_lvl);
    edge_t e;
    e.rise = now_lvl & ~last_lvl;
    e.fall = ~now_lvl & last_lvl;
    return e;
  endfunction

  // Sticky flag pair: set has priority over write-one-to-clear.
  function automatic pair_t w1c_next(input pair_t cur, input pair_t clr, input pair_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic int rise_idx(input int ch);
    return 2 * ch;
  endfunction

  function automatic int fall_idx(input int ch);
    return 2 * ch + 1;
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync
  import cap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic rise_evt,
  output logic fall_evt
);

  logic [STAGES-1:0] shreg;
  logic              lvl;
  logic              lvl_q;
  edge_t             evt;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign lvl = shreg[STAGES-1] ^ inv;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign evt      = classify(lvl, lvl_q);
  assign rise_evt = evt.rise;
  assign fall_evt = evt.fall;

endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_cnt(input logic on, input logic adv,
                                                 input logic [CNT_W-1:0] cur);
    if (!on)      return '0;
    else if (adv) return cur + ONE;
    else          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(en, tick, cnt);
  end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pin,
  input  logic             inv,
  input  logic             tick,
  input  pair_t            stat_clr,
  input  pair_t            ld_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rise_q,
  output logic [CNT_W-1:0] fall_q,
  output pair_t            ld_q,
  output pair_t            stat_q,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic  rise_hit;
  logic  fall_hit;
  pair_t hits;

  cap_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (pin),
    .inv      (inv),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cap_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick),
    .cnt   (cnt)
  );

  assign rise_hit = en & rise_evt;
  assign fall_hit = en & fall_evt;
  assign hits     = {fall_hit, rise_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      ld_q   <= '0;
      stat_q <= '0;
    end else begin
      if (rise_hit) rise_q <= cnt;
      if (fall_hit) fall_q <= cnt;
      ld_q   <= w1c_next(ld_q, ld_clr, hits);
      stat_q <= w1c_next(stat_q, stat_clr, hits);
    end
  end

endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     cap_en,
  input  logic [NCH-1:0]     cap_pin,
  input  logic [NCH-1:0]     inv_pin,
  input  logic               tick,
  input  logic [2*NCH-1:0]   irq_en,
  input  logic [2*NCH-1:0]   stat_clr,
  input  logic [2*NCH-1:0]   ld_clr,
  output logic [NCH*CNT_W-1:0] cap_cnt,
  output logic [NCH*CNT_W-1:0] rise_cap,
  output logic [NCH*CNT_W-1:0] fall_cap,
  output logic [2*NCH-1:0]   loaded,
  output logic [2*NCH-1:0]   irq_stat,
  output logic               irq
);

  logic [NCH-1:0] rise_evt;
  logic [NCH-1:0] fall_evt;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int RB = rise_idx(c);
      localparam int FB = fall_idx(c);
      pair_t s_clr, l_clr, l_q, s_q;

      assign s_clr = {stat_clr[FB], stat_clr[RB]};
      assign l_clr = {ld_clr[FB], ld_clr[RB]};

      cap_channel #(.CNT_W(CNT_W), .STAGES(STAGES)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cap_en[c]),
        .pin      (cap_pin[c]),
        .inv      (inv_pin[c]),
        .tick     (tick),
        .stat_clr (s_clr),
        .ld_clr   (l_clr),
        .cnt      (cap_cnt[c*CNT_W +: CNT_W]),
        .rise_q   (rise_cap[c*CNT_W +: CNT_W]),
        .fall_q   (fall_cap[c*CNT_W +: CNT_W]),
        .ld_q     (l_q),
        .stat_q   (s_q),
        .rise_evt (rise_evt[c]),
        .fall_evt (fall_evt[c])
      );

      assign loaded[RB]   = l_q[0];
      assign loaded[FB]   = l_q[1];
      assign irq_stat[RB] = s_q[0];
      assign irq_stat[FB] = s_q[1];
    end
  endgenerate

  assign irq = |(irq_stat & irq_en);

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       cap_en,
  input logic [NCH-1:0]       cap_pin,
  input logic [NCH-1:0]       inv_pin,
  input logic                 tick,
  input logic [2*NCH-1:0]     irq_en,
  input logic [2*NCH-1:0]     stat_clr,
  input logic [2*NCH-1:0]     ld_clr,
  input logic [NCH*CNT_W-1:0] cap_cnt,
  input logic [NCH*CNT_W-1:0] rise_cap,
  input logic [NCH*CNT_W-1:0] fall_cap,
  input logic [2*NCH-1:0]     loaded,
  input logic [2*NCH-1:0]     irq_stat,
  input logic                 irq,
  input logic [NCH-1:0]       rise_evt,
  input logic [NCH-1:0]       fall_evt
);

  logic unused_ok;
  assign unused_ok = ^{cap_pin, inv_pin, stat_clr};

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);  // R8

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      AST_CNT_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en[c] |=> (cap_cnt[c*CNT_W +: CNT_W] == '0));  // R2

      AST_CNT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en[c] && !tick) |=> $stable(cap_cnt[c*CNT_W +: CNT_W]));  // R2

      AST_CNT_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en[c] && tick) |=>
          (cap_cnt[c*CNT_W +: CNT_W] == CNT_W'($past(cap_cnt[c*CNT_W +: CNT_W]) + 1'b1)));  // R3

      AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_evt[c] && fall_evt[c]));  // R4

      AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en[c] && rise_evt[c]) |=>
          (rise_cap[c*CNT_W +: CNT_W] == $past(cap_cnt[c*CNT_W +: CNT_W]))
          && loaded[2*c] && irq_stat[2*c]);  // R4

      AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en[c] && fall_evt[c]) |=>
          (fall_cap[c*CNT_W +: CNT_W] == $past(cap_cnt[c*CNT_W +: CNT_W]))
          && loaded[2*c+1] && irq_stat[2*c+1]);  // R5

      AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en[c] |=> ($stable(rise_cap[c*CNT_W +: CNT_W])
                        && $stable(fall_cap[c*CNT_W +: CNT_W])));  // R10

      AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded[2*c] && !ld_clr[2*c]) |=> loaded[2*c]);  // R6
    end
  endgenerate

endmodule

bind cap_unit cap_unit_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_cap_unit.sv
`timescale 1ns/1ps
module test_cap_unit;

  localparam int NCH = 2;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]   cap_en, cap_pin, inv_pin;
  logic             tick;
  logic [2*NCH-1:0] irq_en, stat_clr, ld_clr;
  logic [NCH*W-1:0] cap_cnt, rise_cap, fall_cap;
  logic [2*NCH-1:0] loaded, irq_stat;
  logic             irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  cap_unit #(.NCH(NCH), .CNT_W(W)) i_cap_unit (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fld(input logic [NCH*W-1:0] v, input int c);
    return v[c*W +: W];
  endfunction

  function automatic logic [W-1:0] stamp(input int k, input int e);
    return W'(k - e + 2);
  endfunction

  task automatic t_reset();
    chk("R1 count", cap_cnt, 0);
    chk("R1 rise", rise_cap, 0);
    chk("R1 fall", fall_cap, 0);
    chk("R1 loaded", loaded, 0);
    chk("R1 status", irq_stat, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_count();
    cap_en[0] = 1'b1;
    step(5);
    chk("R2 counting", fld(cap_cnt, 0), 5);
    tick = 1'b0;
    step(3);
    chk("R2 hold without tick", fld(cap_cnt, 0), 5);
    tick = 1'b1;
    cap_en[0] = 1'b0;
    step(1);
    chk("R2 zero when disabled", fld(cap_cnt, 0), 0);
  endtask

  task automatic t_edges_flags();
    int e, k, k2, k5;
    e = cyc + 1;
    cap_en[0] = 1'b1;
    step(4);
    k = cyc + 1; cap_pin[0] = 1'b1;
    step(3);
    chk("R4 rise value", fld(rise_cap, 0), stamp(k, e));
    chk("R4 rise flags", {loaded[1:0], irq_stat[1:0]}, 4'b0101);
    chk("R5 fall untouched", fld(fall_cap, 0), 0);
    step(2);
    k2 = cyc + 1; cap_pin[0] = 1'b0;
    step(3);
    chk("R5 fall value", fld(fall_cap, 0), stamp(k2, e));
    chk("R5 rise kept", fld(rise_cap, 0), stamp(k, e));
    chk("R5 flags", {loaded[1:0], irq_stat[1:0]}, 4'b1111);
    ld_clr = 4'b0001; step(1); ld_clr = '0;
    chk("R6 w1c loaded", loaded[1:0], 2'b10);
    stat_clr = 4'b0011; step(1); stat_clr = '0;
    chk("R7 w1c status", irq_stat[1:0], 2'b00);
    k = cyc + 1; cap_pin[0] = 1'b1;
    step(3);
    chk("R6 rise rewritten", fld(rise_cap, 0), stamp(k, e));
    k2 = cyc + 1; cap_pin[0] = 1'b0;
    step(3);
    chk("R6 overwrite while loaded", fld(fall_cap, 0), stamp(k2, e));
    k5 = cyc + 1; cap_pin[0] = 1'b1;
    step(2);
    stat_clr = 4'b0001; ld_clr = 4'b0001;
    step(1);
    stat_clr = '0; ld_clr = '0;
    chk("R7 set beats clear", irq_stat[0], 1);
    chk("R6 set beats clear", loaded[0], 1);
    chk("R4 same-edge value", fld(rise_cap, 0), stamp(k5, e));
  endtask

  task automatic t_irq();
    stat_clr = '1; step(1); stat_clr = '0;
    irq_en = '0;
    cap_pin[0] = 1'b0;
    step(3);
    chk("R7 status without enable", irq_stat[1:0], 2'b10);
    chk("R8 masked", irq, 0);
    irq_en = 4'b0001; #1;
    chk("R8 other bit enabled", irq, 0);
    irq_en = 4'b0010; #1;
    chk("R8 enabled raises irq", irq, 1);
    irq_en = '0; #1;
    chk("R8 disabled drops irq", irq, 0);
    stat_clr = '1; ld_clr = '1; step(1); stat_clr = '0; ld_clr = '0;
  endtask

  task automatic t_disabled();
    logic [W-1:0] r0, f0;
    cap_en[0] = 1'b0;
    step(2);
    r0 = fld(rise_cap, 0); f0 = fld(fall_cap, 0);
    cap_pin[0] = 1'b1; step(4);
    cap_pin[0] = 1'b0; step(4);
    chk("R10 rise kept", fld(rise_cap, 0), r0);
    chk("R10 fall kept", fld(fall_cap, 0), f0);
    chk("R10 no flags", {loaded, irq_stat}, 0);
  endtask

  task automatic t_invert();
    int e, k;
    inv_pin[1] = 1'b1; cap_pin[1] = 1'b0;
    step(4);
    e = cyc + 1; cap_en[1] = 1'b1;
    step(3);
    k = cyc + 1; cap_pin[1] = 1'b1;
    step(3);
    chk("R9 rising pin into fall reg", fld(fall_cap, 1), stamp(k, e));
    chk("R9 flags ch1", loaded[3:2], 2'b10);
    chk("R9 rise reg untouched", fld(rise_cap, 1), 0);
    chk("R11 ch0 untouched", {loaded[1:0], fld(cap_cnt, 0)}, 0);
    k = cyc + 1; cap_pin[1] = 1'b0;
    step(3);
    chk("R9 falling pin into rise reg", fld(rise_cap, 1), stamp(k, e));
  endtask

  task automatic t_tick_gate();
    int k;
    cap_en[1] = 1'b0; inv_pin[1] = 1'b0; tick = 1'b0;
    step(4);
    cap_en[1] = 1'b1;
    step(3);
    chk("R2 no tick stays zero", fld(cap_cnt, 1), 0);
    tick = 1'b1; step(1); tick = 1'b0;
    chk("R2 single tick", fld(cap_cnt, 1), 1);
    k = cyc + 1; cap_pin[1] = 1'b1;
    step(3);
    chk("R4 gated stamp", fld(rise_cap, 1), 1);
    tick = 1'b1;
  endtask

  task automatic t_wrap();
    int e, k;
    cap_en[1] = 1'b0; step(1);
    e = cyc + 1; cap_en[1] = 1'b1;
    step(65539);
    chk("R3 wrapped count", fld(cap_cnt, 1), 3);
    k = cyc + 1; cap_pin[1] = 1'b0;
    step(3);
    chk("R3 wrapped stamp", fld(fall_cap, 1), stamp(k, e));
  endtask

  initial begin
    rst_n = 1'b0; cap_en = '0; cap_pin = '0; inv_pin = '0; tick = 1'b1;
    irq_en = '0; stat_clr = '0; ld_clr = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_count();
    t_edges_flags();
    t_irq();
    t_disabled();
    t_invert();
    t_tick_gate();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule